// File: doc/BRIEF.md
# Parity Bus Transceiver with Error-Flag Latch

This block bridges an 8-bit A bus and a 9-bit B bus, where the B bus carries eight data bits plus one parity bit. Two active-low enables choose among four modes: A drives B with a generated parity bit, B drives A with its parity checked, A drives B with the parity bit deliberately inverted to provoke an error downstream, or both buses are left undriven. Each bus side is modelled as separate input, output and drive-enable signals, so that the block can sit in front of pad cells or an on-chip bus fabric.

A parity check result is computed in every mode. It feeds a one-bit error flag, which is read as an active-low output. A latch-enable and an active-low clear select how the flag behaves. While the latch-enable is high, the flag follows the check. On the cycle the latch-enable falls, the check is captured, and a flag that is already low stays low. While the latch-enable stays low, the flag holds. The clear forces the flag back to "no error". The model is fully synchronous: one clock samples the latch-enable, and its falling edge is detected from the previous cycle's value.

Top module: `pbx_parity_xcvr`

## Requirements
- R1: With a_oe_n=1 and b_oe_n=0, b_out equals a_in, b_drv=1, par_drv=1 and a_drv=0. par_out is 1 exactly when a_in holds an even number of ones, so the nine B-side bits carry odd parity.
- R2: With a_oe_n=0 and b_oe_n=1, a_out equals b_in, a_drv=1, b_drv=0 and par_drv=0.
- R3: With a_oe_n=0 and b_oe_n=0, b_out equals a_in and b_drv=par_drv=1, while par_out is the complement of the R1 parity bit. a_drv=0.
- R4: With a_oe_n=1 and b_oe_n=1, a_drv, b_drv and par_drv are all 0. In every mode, an output whose drive enable is 0 reads as all zeros.
- R5: The check result is "good" in R1 mode and "bad" in R3 mode. In R2 mode it is good exactly when b_in together with par_in holds an odd number of ones. In R4 mode it is good exactly when a_in holds an odd number of ones.
- R6: While le=1, err_n after the next clock edge equals the check result of this cycle (1 = good, 0 = error), whatever the value of clr_n.
- R7: In a cycle where le is 0 and was 1 in the previous cycle, and clr_n=1, the next err_n is the old err_n AND the check result. A flag that is already low stays low.
- R8: While le is 0 for a second or later cycle and clr_n=1, err_n keeps its value whatever the bus data.
- R9: In any cycle with le=0 and clr_n=0, including the cycle in which le falls, err_n is 1 after the next clock edge.
- R10: While rst_n=0, err_n becomes 1 at the next clock edge and the latch-enable history is cleared. A low le in the first cycle after reset therefore acts as hold, not as a falling edge.
- R11: a_drv and b_drv are never both 1, and par_drv always equals b_drv.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_oe_n | input | 1 | Active-low enable of the A-side drivers |
| b_oe_n | input | 1 | Active-low enable of the B-side drivers |
| le | input | 1 | Error-flag latch enable: high follows the check, falling edge captures it |
| clr_n | input | 1 | Active-low error-flag clear, effective while le is low |
| a_in | input | 8 | Value seen on the A bus |
| a_out | output | 8 | Value driven onto the A bus |
| a_drv | output | 1 | A bus drive enable |
| b_in | input | 8 | Data value seen on the B bus |
| b_out | output | 8 | Data value driven onto the B bus |
| b_drv | output | 1 | B data drive enable |
| par_in | input | 1 | Parity bit seen on the B bus |
| par_out | output | 1 | Parity bit driven onto the B bus |
| par_drv | output | 1 | Parity bit drive enable |
| err_n | output | 1 | Registered parity error flag, low means error |

## Verification
The hardest state to reach is the sticky capture. The flag must already be low when le falls while the check is good, and then it must stay low. To get there, the bench first lets a bad B word pass through with le high, then drops le in the same cycle that it presents a good word. A second sequence captures a bad word on the falling edge from a good flag. Two further sequences lower clr_n on the falling-edge cycle and while le is high, which separates the clear rule from the pass rule.

// File: rtl/pbx_pkg.sv
// Shared types for the parity bus transceiver.
// Assumes: both output enables are active low; the enable pair fully selects the mode.
package pbx_pkg;

    typedef enum logic [1:0] {
        XM_A2B     = 2'd0,
        XM_B2A     = 2'd1,
        XM_A2B_INV = 2'd2,
        XM_ISOLATE = 2'd3
    } xfer_mode_e;

    // Map the two active-low enables onto a transfer mode.
    function automatic xfer_mode_e decode_mode(input logic a_oe_n, input logic b_oe_n);
        case ({a_oe_n, b_oe_n})
            2'b10:   return XM_A2B;
            2'b01:   return XM_B2A;
            2'b00:   return XM_A2B_INV;
            default: return XM_ISOLATE;
        endcase
    endfunction

endpackage

// File: rtl/pbx_parity_unit.sv
// Parity generator and checker.
// Produces the odd-fill parity bit for the A word. Also produces the per-mode
// check result (1 = good), which feeds the error-flag latch.
// Assumes: the mode is already decoded; purely combinational.
module pbx_parity_unit
    import pbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              par_in,
    input  xfer_mode_e        mode,
    output logic              gen_par,
    output logic              chk_ok
);

    logic [DATA_W:0] a_chain;
    logic [DATA_W:0] b_chain;

    assign a_chain[0] = 1'b0;
    assign b_chain[0] = par_in;

    // XOR chains: one bit of each word per stage.
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_xor_stage
            assign a_chain[i+1] = a_chain[i] ^ a_in[i];
            assign b_chain[i+1] = b_chain[i] ^ b_in[i];
        end
    endgenerate

    logic a_odd;
    logic b_word_odd;
    assign a_odd      = a_chain[DATA_W];
    assign b_word_odd = b_chain[DATA_W];

    // Generated bit makes the nine-bit word odd.
    assign gen_par = ~a_odd;

    // Check result seen by the flag in each mode.
    always_comb begin
        case (mode)
            XM_A2B:     chk_ok = 1'b1;
            XM_A2B_INV: chk_ok = 1'b0;
            XM_B2A:     chk_ok = b_word_odd;
            default:    chk_ok = a_odd;
        endcase
    end

endmodule

// File: rtl/pbx_path_mux.sv
// Bus steering: sets the drive enables and the outgoing values for each mode.
// Assumes: an undriven output is held at zero so that it never floats in the model.
module pbx_path_mux
    import pbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  xfer_mode_e        mode,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              gen_par,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drv,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drv,
    output logic              par_out,
    output logic              par_drv
);

    // Select the direction and the parity polarity from the mode.
    always_comb begin
        a_out   = '0;
        a_drv   = 1'b0;
        b_out   = '0;
        b_drv   = 1'b0;
        par_out = 1'b0;
        par_drv = 1'b0;
        case (mode)
            XM_A2B: begin
                b_out   = a_in;
                b_drv   = 1'b1;
                par_out = gen_par;
                par_drv = 1'b1;
            end
            XM_A2B_INV: begin
                b_out   = a_in;
                b_drv   = 1'b1;
                par_out = ~gen_par;
                par_drv = 1'b1;
            end
            XM_B2A: begin
                a_out = b_in;
                a_drv = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pbx_err_latch.sv
// Error-flag latch, modelled synchronously.
// le high: the flag follows the check. Falling le: sticky capture.
// le low: hold. le low with clr_n low: clear to "no error".
// Assumes: le and clr_n are synchronous to clk; reset is synchronous, active low.
module pbx_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic le_i,
    input  logic clr_n_i,
    input  logic chk_ok_i,
    output logic err_n_o
);

    logic le_q;
    logic le_fall;

    // Remember last cycle's latch enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= le_i;
    end

    assign le_fall = le_q & ~le_i;

    // Flag update: pass, clear, sticky sample, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_n_o <= 1'b1;
        else if (le_i)     err_n_o <= chk_ok_i;
        else if (!clr_n_i) err_n_o <= 1'b1;
        else if (le_fall)  err_n_o <= err_n_o & chk_ok_i;
    end

    // R6
    pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_i |=> (err_n_o == $past(chk_ok_i)));

    // R7
    sticky_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_fall && clr_n_i && !err_n_o) |=> !err_n_o);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !le_q && clr_n_i) |=> $stable(err_n_o));

    // R9
    clear_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !clr_n_i) |=> err_n_o);

    // R10
    reset_flag_chk: assert property (@(posedge clk)
        !rst_n |=> err_n_o);

endmodule

// File: rtl/pbx_parity_xcvr.sv
// Top of the parity bus transceiver.
// Decodes the enables, steers the buses, generates and checks parity, and keeps
// the latched active-low error flag.
// Assumes: tri-state buses are split into in/out/drive-enable at the pads.
module pbx_parity_xcvr
    import pbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_oe_n,
    input  logic              b_oe_n,
    input  logic              le,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drv,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drv,
    input  logic              par_in,
    output logic              par_out,
    output logic              par_drv,
    output logic              err_n
);

    xfer_mode_e mode;
    logic       gen_par;
    logic       chk_ok;

    // Mode from the enable pair.
    assign mode = decode_mode(a_oe_n, b_oe_n);

    pbx_parity_unit #(.DATA_W(DATA_W)) par_u (
        .a_in    (a_in),
        .b_in    (b_in),
        .par_in  (par_in),
        .mode    (mode),
        .gen_par (gen_par),
        .chk_ok  (chk_ok)
    );

    pbx_path_mux #(.DATA_W(DATA_W)) mux_u (
        .mode    (mode),
        .a_in    (a_in),
        .b_in    (b_in),
        .gen_par (gen_par),
        .a_out   (a_out),
        .a_drv   (a_drv),
        .b_out   (b_out),
        .b_drv   (b_drv),
        .par_out (par_out),
        .par_drv (par_drv)
    );

    pbx_err_latch flag_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .le_i     (le),
        .clr_n_i  (clr_n),
        .chk_ok_i (chk_ok),
        .err_n_o  (err_n)
    );

    // R11
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_drv && b_drv));

    // R11
    par_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_drv == b_drv);

    // R1
    odd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_n && !b_oe_n) |-> (^{b_out, par_out}));

    // R3
    forced_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_oe_n && !b_oe_n) |-> !(^{b_out, par_out}));

endmodule

// File: tb/pbx_parity_xcvr_tb_top.sv
`timescale 1ns/1ps
module pbx_parity_xcvr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a_oe_n, b_oe_n, le, clr_n, par_in;
    logic [7:0] a_in, b_in;
    logic [7:0] a_out, b_out;
    logic       a_drv, b_drv, par_out, par_drv, err_n;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pbx_parity_xcvr #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
        .le(le), .clr_n(clr_n), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv), .par_in(par_in),
        .par_out(par_out), .par_drv(par_drv), .err_n(err_n)
    );

    // Vector: {oea, oeb, a, b, par | e_adrv, e_bdrv, e_pdrv, e_aout, e_bout, e_par, e_err}
    localparam int NVEC = 9;
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b1,1'b0,8'hA5,8'h00,1'b0, 1'b0,1'b1,1'b1,8'h00,8'hA5,1'b1,1'b1},
        {1'b1,1'b0,8'h07,8'h00,1'b0, 1'b0,1'b1,1'b1,8'h00,8'h07,1'b0,1'b1},
        {1'b0,1'b0,8'hA5,8'h00,1'b0, 1'b0,1'b1,1'b1,8'h00,8'hA5,1'b0,1'b0},
        {1'b0,1'b0,8'h07,8'h00,1'b0, 1'b0,1'b1,1'b1,8'h00,8'h07,1'b1,1'b0},
        {1'b0,1'b1,8'hFF,8'h3C,1'b1, 1'b1,1'b0,1'b0,8'h3C,8'h00,1'b0,1'b1},
        {1'b0,1'b1,8'hFF,8'h3C,1'b0, 1'b1,1'b0,1'b0,8'h3C,8'h00,1'b0,1'b0},
        {1'b0,1'b1,8'h00,8'h01,1'b0, 1'b1,1'b0,1'b0,8'h01,8'h00,1'b0,1'b1},
        {1'b1,1'b1,8'h0F,8'h55,1'b1, 1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0},
        {1'b1,1'b1,8'h0E,8'h55,1'b1, 1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock edge, then sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_b2a(input logic good);
        a_oe_n = 1'b0; b_oe_n = 1'b1;
        b_in   = 8'h3C; par_in = good;   // 4 ones + par: odd when par=1
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; le = 1'b0; clr_n = 1'b1; a_in = 8'h00;
        drive_b2a(1'b0);
        @(negedge clk);
        step();
        check("R10", "err_n in reset", err_n, 1'b1);
        rst_n = 1'b1;
        step();
        check("R10", "first low le after reset holds", err_n, 1'b1);

        // Table walk in pass mode (le high).
        le = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            string req;
            a_oe_n = VEC[i][39]; b_oe_n = VEC[i][38];
            a_in   = VEC[i][37:30]; b_in = VEC[i][29:22]; par_in = VEC[i][21];
            step();
            case ({a_oe_n, b_oe_n})
                2'b10:   req = "R1";
                2'b01:   req = "R2";
                2'b00:   req = "R3";
                default: req = "R4";
            endcase
            check(req, "a_drv",   a_drv,   VEC[i][20]);
            check(req, "b_drv",   b_drv,   VEC[i][19]);
            check(req, "par_drv", par_drv, VEC[i][18]);
            check(req, "a_out",   a_out,   VEC[i][17:10]);
            check(req, "b_out",   b_out,   VEC[i][9:2]);
            check(req, "par_out", par_out, VEC[i][1]);
            check("R5", "err_n after pass", err_n, VEC[i][0]);
            check("R11", "drive exclusive", a_drv & b_drv, 1'b0);
            check("R11", "par_drv tie", par_drv, b_drv);
        end

        // Sticky capture: flag low, le falls with good data.
        drive_b2a(1'b0); le = 1'b1; step();
        check("R6", "pass bad", err_n, 1'b0);
        drive_b2a(1'b1); le = 1'b0; step();
        check("R7", "sticky on fall", err_n, 1'b0);
        step();
        check("R8", "hold low", err_n, 1'b0);

        clr_n = 1'b0; step();
        check("R9", "clear while low", err_n, 1'b1);
        clr_n = 1'b1;

        // Capture a bad word on the falling edge from a good flag.
        le = 1'b1; drive_b2a(1'b1); step();
        check("R6", "pass good", err_n, 1'b1);
        le = 1'b0; drive_b2a(1'b0); step();
        check("R7", "capture bad on fall", err_n, 1'b0);
        drive_b2a(1'b1); step();
        check("R8", "good data ignored in hold", err_n, 1'b0);

        // Hold keeps a good flag against bad data.
        clr_n = 1'b0; step(); clr_n = 1'b1;
        le = 1'b1; drive_b2a(1'b1); step();
        le = 1'b0; step();
        check("R7", "good capture", err_n, 1'b1);
        drive_b2a(1'b0); step();
        check("R8", "bad data ignored in hold", err_n, 1'b1);
        step();
        check("R8", "still held", err_n, 1'b1);

        // Clear on the falling-edge cycle beats the capture.
        le = 1'b1; drive_b2a(1'b0); step();
        check("R6", "pass bad again", err_n, 1'b0);
        le = 1'b0; clr_n = 1'b0; step();
        check("R9", "clear on fall", err_n, 1'b1);

        // Clear has no effect while le is high.
        le = 1'b1; clr_n = 1'b0; drive_b2a(1'b0); step();
        check("R6", "clr ignored in pass (bad)", err_n, 1'b0);
        drive_b2a(1'b1); step();
        check("R6", "clr ignored in pass (good)", err_n, 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule